// File: doc/BRIEF.md
# Oversampled Framed SPI Slave Port

This block is the slave side of a serial port run with its bit clock stopped between words. An external master drives the serial clock, an active-low slave enable and the MOSI line; the block returns data on MISO. Every input from the master is taken through an internal sample clock enable that runs at half the system clock, passed through a two-stage synchronizer and edge-detected in the system domain, so the whole block runs on one clock. The external serial clock must be no faster than one quarter of the system clock.

Each word, whose length is a parameter (16 bits by default, most significant bit first), needs its own falling edge on the slave enable. Keeping the enable low after a word does not start another. The clock polarity and one of two phase modes (no delay, or a half-cycle delay) are chosen by inputs. The data delay between the enable edge and the first bit must be zero; any other setting is rejected. Software side: a parallel holding register for the next transmit word with a load strobe and a ready flag, and a parallel receive word with a one-cycle valid strobe, plus one-cycle underflow and framing-error pulses.

Top module: `fspi_slave`

## Requirements
- R1: After reset, misoOe is 0, rxValid is 0, txReady is 1, underflow and frameErr are 0.
- R2: With phaseDelay=0, the first transmit bit is presented on misoOut after the enable falls, MOSI is captured on each leading edge of the serial clock and misoOut moves to the next bit on each trailing edge; bits travel most significant first.
- R3: With phaseDelay=1, misoOut presents the first bit after the first leading edge and the next bit after each later leading edge, and MOSI is captured on each trailing edge.
- R4: With clkPol=0 the serial clock idles low and its leading edge is the rising edge; with clkPol=1 it idles high and its leading edge is the falling edge.
- R5: When the last bit of a word is captured, rxWord takes the received word and rxValid is high for exactly one clock cycle.
- R6: A txLoad pulse stores txWord in the holding register and drives txReady to 0; the register is emptied (txReady back to 1) when a transfer starts.
- R7: A transfer that starts with an empty holding register sends all-zero bits and raises underflow for exactly one clock cycle.
- R8: A transfer starts only on a falling edge of csN; serial clock edges while csN stays low after a complete word produce no rxValid, and misoOe stays 1 until csN rises.
- R9: If csN rises before the last bit is captured, the partial word is discarded (no rxValid), frameErr pulses for one cycle, and the next full transfer delivers its own word correctly.
- R10: misoOe is 0 while no transfer is open, so MISO is released whenever the slave enable is deasserted.
- R11: A nonzero delaySel raises cfgReject and prevents any transfer from starting: misoOe stays 0, no rxValid, no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock from the master |
| csN | input | 1 | Active-low slave enable from the master |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for MISO (0 = high impedance) |
| clkPol | input | 1 | Serial clock polarity, 1 = idles high |
| phaseDelay | input | 1 | 1 selects the half-cycle delayed phase mode |
| delaySel | input | 2 | Data delay setting, only 0 is accepted |
| txWord | input | WORD_W | Next word to transmit |
| txLoad | input | 1 | Strobe that writes txWord to the holding register |
| txReady | output | 1 | Holding register is empty |
| rxWord | output | WORD_W | Last complete received word |
| rxValid | output | 1 | One-cycle strobe for a new rxWord |
| underflow | output | 1 | One-cycle pulse, transfer started with no loaded word |
| frameErr | output | 1 | One-cycle pulse, enable released mid-word |
| cfgReject | output | 1 | delaySel holds an unsupported value |

## Verification
The hardest state to reach from the ports is a slave enable that stays low after a finished word while the master keeps clocking, because a normal master always releases the enable. The bench master has a hold option that leaves csN low after the last bit and then issues a further full word of clock pulses, so the block is kept in its post-word state under live clock edges; the scoreboard then flags any stray rxValid and misoOe is sampled before release. A mid-word release is reached the same way by cutting the bit loop short.

// File: rtl/fspi_pkg.sv
package fspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD
  } fspiState_t;

  typedef struct packed {
    logic start;
    logic sampleBit;
    logic shiftOut;
    logic wordDone;
  } fspiStrobe_t;

endpackage

// File: rtl/fspi_sampler.sv
module fspi_sampler #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic             sampleTick;
  logic             tickDly;
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] prevB;

  // Sample clock enable at half the system rate.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleTick <= 1'b0;
      tickDly    <= 1'b0;
    end else begin
      sampleTick <= ~sampleTick;
      tickDly    <= sampleTick;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= RST_VAL;
      syncB <= RST_VAL;
      prevB <= RST_VAL;
    end else if (sampleTick) begin
      syncA <= rawIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign level = syncB;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    assign rise[i] = tickDly & syncB[i] & ~prevB[i];
    assign fall[i] = tickDly & ~syncB[i] & prevB[i];
  end

endmodule

// File: rtl/fspi_ctrl.sv
module fspi_ctrl
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csFall,
  input  logic        csRise,
  input  logic        sckLead,
  input  logic        sckTrail,
  input  logic        phaseDelay,
  input  logic        cfgOk,
  output fspiStrobe_t strobe,
  output logic        busy,
  output logic        frameErr
);

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  fspiState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic firstDrive;
  logic sampleEdge;
  logic driveEdge;

  assign sampleEdge = phaseDelay ? sckTrail : sckLead;
  assign driveEdge  = phaseDelay ? sckLead  : sckTrail;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (csFall && cfgOk) begin
          strobe.start = 1'b1;
          stateNxt     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (csRise) begin
          stateNxt = ST_IDLE;
        end else if (sampleEdge) begin
          strobe.sampleBit = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strobe.wordDone = 1'b1;
            stateNxt        = ST_HOLD;
          end
        end else if (driveEdge && !(phaseDelay && firstDrive)) begin
          strobe.shiftOut = 1'b1;
        end
      end
      ST_HOLD: begin
        if (csRise) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      firstDrive <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      state    <= stateNxt;
      frameErr <= (state == ST_SHIFT) && csRise;
      if (strobe.start) begin
        bitCnt     <= '0;
        firstDrive <= 1'b1;
      end else begin
        if (strobe.sampleBit) bitCnt <= bitCnt + 1'b1;
        if (state == ST_SHIFT && driveEdge) firstDrive <= 1'b0;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fspi_datapath.sv
module fspi_datapath
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fspiStrobe_t       strobe,
  input  logic              mosiBit,
  input  logic              txLoad,
  input  logic [WORD_W-1:0] txWord,
  output logic              txReady,
  output logic              misoBit,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              underflow
);

  logic [WORD_W-1:0] holdReg;
  logic              holdFull;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  assign rxNext = {rxShift[WORD_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (txLoad) begin
        holdReg  <= txWord;
        holdFull <= 1'b1;
      end else if (strobe.start) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      underflow <= 1'b0;
    end else begin
      underflow <= strobe.start && !holdFull;
      if (strobe.start) txShift <= holdFull ? holdReg : '0;
      else if (strobe.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobe.wordDone;
      if (strobe.sampleBit) rxShift <= rxNext;
      if (strobe.wordDone) rxWord <= rxNext;
    end
  end

  assign txReady = !holdFull;
  assign misoBit = txShift[WORD_W-1];

endmodule

// File: rtl/fspi_slave.sv
module fspi_slave
  import fspi_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              clkPol,
  input  logic              phaseDelay,
  input  logic [1:0]        delaySel,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txLoad,
  output logic              txReady,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              underflow,
  output logic              frameErr,
  output logic              cfgReject
);

  localparam int IDX_MOSI = 0;
  localparam int IDX_SCK  = 1;
  localparam int IDX_CS   = 2;

  logic [2:0]  rawIn;
  logic [2:0]  lvl;
  logic [2:0]  riseEv;
  logic [2:0]  fallEv;
  logic        cfgOk;
  logic        busy;
  fspiStrobe_t strobe;

  assign rawIn = {csN, sckIn ^ clkPol, mosiIn};
  assign cfgOk = (delaySel == 2'b00);
  assign cfgReject = !cfgOk;

  fspi_sampler #(.WIDTH(3), .RST_VAL(3'b100)) u_sampler (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn (rawIn),
    .level (lvl),
    .rise  (riseEv),
    .fall  (fallEv)
  );

  fspi_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csFall     (fallEv[IDX_CS]),
    .csRise     (riseEv[IDX_CS]),
    .sckLead    (riseEv[IDX_SCK]),
    .sckTrail   (fallEv[IDX_SCK]),
    .phaseDelay (phaseDelay),
    .cfgOk      (cfgOk),
    .strobe     (strobe),
    .busy       (busy),
    .frameErr   (frameErr)
  );

  fspi_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mosiBit   (lvl[IDX_MOSI]),
    .txLoad    (txLoad),
    .txWord    (txWord),
    .txReady   (txReady),
    .misoBit   (misoOut),
    .rxWord    (rxWord),
    .rxValid   (rxValid),
    .underflow (underflow)
  );

  assign misoOe = busy;

endmodule

// File: rtl/fspi_slave_chk.sv
module fspi_slave_chk (
  input logic clk,
  input logic rstN,
  input logic misoOut,
  input logic misoOe,
  input logic txLoad,
  input logic txReady,
  input logic rxValid,
  input logic underflow,
  input logic frameErr,
  input logic cfgReject
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R5

  AST_FRAME_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr); // R9

  AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && frameErr)); // R9

  AST_LOAD_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txReady); // R6

  AST_UNDERFLOW_SENDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (misoOe && !misoOut)); // R7

  AST_UNDERFLOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> !underflow); // R7

  AST_REJECT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReject && !misoOe) |=> !misoOe); // R11

endmodule

bind fspi_slave fspi_slave_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .misoOut   (misoOut),
  .misoOe    (misoOe),
  .txLoad    (txLoad),
  .txReady   (txReady),
  .rxValid   (rxValid),
  .underflow (underflow),
  .frameErr  (frameErr),
  .cfgReject (cfgReject)
);

// File: tb/test_fspi_slave.sv
`timescale 1ns/1ps
module test_fspi_slave;

  localparam int W = 16;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csN = 1'b1, mosiIn = 1'b0;
  logic clkPol = 1'b0, phaseDelay = 1'b0;
  logic [1:0] delaySel = 2'b00;
  logic [W-1:0] txWord = '0;
  logic txLoad = 1'b0;
  logic misoOut, misoOe, txReady, rxValid, underflow, frameErr, cfgReject;
  logic [W-1:0] rxWord;

  int nTests = 0, nFail = 0;
  int nValid = 0, nErr = 0, nUnder = 0;
  bit oeSeen = 0;
  bit doneFlag = 0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] capMiso;

  always #5 clk = ~clk;

  fspi_slave #(.WORD_W(W)) i_fspi_slave (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .clkPol(clkPol), .phaseDelay(phaseDelay),
    .delaySel(delaySel), .txWord(txWord), .txLoad(txLoad), .txReady(txReady),
    .rxWord(rxWord), .rxValid(rxValid), .underflow(underflow),
    .frameErr(frameErr), .cfgReject(cfgReject)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on each received word, event counters.
  always @(negedge clk) begin
    if (rstN) begin
      if (misoOe) oeSeen = 1;
      if (underflow) nUnder++;
      if (frameErr) nErr++;
      if (rxValid) begin
        nValid++;
        if (expQ.size() == 0) begin
          chk(0, "R8", "unexpected rxValid", {16'h0, rxWord}, 32'h0);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          chk(rxWord == e, "R5", "received word", {16'h0, rxWord}, {16'h0, e});
        end
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTx(input logic [W-1:0] w);
    @(negedge clk);
    txWord = w;
    txLoad = 1'b1;
    @(negedge clk);
    txLoad = 1'b0;
  endtask

  // Master: sends nbits of m; pushes m to the scoreboard when a word is expected.
  task automatic xfer(input logic [W-1:0] m, input int nbits, input bit expectWord,
                      input bit keepLow);
    if (expectWord) expQ.push_back(m);
    capMiso = '0;
    sckIn = clkPol;
    csN = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (!phaseDelay) mosiIn = m[W-1-i];
      waitClk(H);
      sckIn = ~clkPol;
      if (!phaseDelay) capMiso[W-1-i] = misoOut;
      else mosiIn = m[W-1-i];
      waitClk(H);
      sckIn = clkPol;
      if (phaseDelay) capMiso[W-1-i] = misoOut;
    end
    waitClk(H);
    if (!keepLow) begin
      csN = 1'b1;
      waitClk(3 * H);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sckIn = ~clkPol; waitClk(H);
      sckIn = clkPol;  waitClk(H);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    int v0;
    waitClk(3);
    // R1 reset state
    chk(misoOe == 0, "R1", "misoOe at reset", misoOe, 0);
    chk(rxValid == 0, "R1", "rxValid at reset", rxValid, 0);
    chk(txReady == 1, "R1", "txReady at reset", txReady, 1);
    chk(underflow == 0 && frameErr == 0, "R1", "pulses at reset", {underflow, frameErr}, 0);
    rstN = 1'b1;
    waitClk(4 * H);
    chk(misoOe == 0, "R10", "misoOe idle", misoOe, 0);

    // R2 R3 R4: all polarity / phase combinations
    for (int k = 0; k < 4; k++) begin
      clkPol = k[0];
      phaseDelay = k[1];
      sckIn = clkPol;
      waitClk(4 * H);
      pat = 16'hA5C3 ^ (16'h1111 * k[3:0]);
      loadTx(pat);
      chk(txReady == 0, "R6", "txReady after load", txReady, 0);
      xfer(16'h1234 + 16'h0F0F * k[15:0], W, 1, 0);
      chk(capMiso == pat, phaseDelay ? "R3" : "R2", "miso word", capMiso, pat);
      chk(txReady == 1, "R6", "txReady after start", txReady, 1);
      chk(misoOe == 0, "R10", "misoOe after release", misoOe, 0);
    end
    chk(clkPol == 1 && nValid == 4, "R4", "words over all polarities", nValid, 4);

    // R7 underflow
    clkPol = 1'b0; phaseDelay = 1'b0; sckIn = 1'b0;
    waitClk(4 * H);
    xfer(16'hBEEF, W, 1, 0);
    chk(capMiso == 0, "R7", "zeros on underflow", capMiso, 0);
    chk(nUnder == 1, "R7", "underflow pulses", nUnder, 1);

    // R8 enable held low after a word: extra clocks do nothing
    loadTx(16'h0FF0);
    xfer(16'h6B2D, W, 1, 1);
    v0 = nValid;
    pulses(W);
    waitClk(2 * H);
    chk(misoOe == 1, "R8", "misoOe while held", misoOe, 1);
    chk(nValid == v0, "R8", "no word while held", nValid, v0);
    csN = 1'b1;
    waitClk(3 * H);
    chk(capMiso == 16'h0FF0, "R8", "miso word before hold", capMiso, 16'h0FF0);
    loadTx(16'h3C3C);
    xfer(16'h9A9A, W, 1, 0);
    chk(capMiso == 16'h3C3C, "R8", "word after re-assertion", capMiso, 16'h3C3C);

    // R9 early release
    loadTx(16'h1357);
    v0 = nValid;
    xfer(16'hFFFF, 5, 0, 0);
    chk(nErr == 1, "R9", "frameErr pulses", nErr, 1);
    chk(nValid == v0, "R9", "no word on early release", nValid, v0);
    loadTx(16'h8001);
    xfer(16'h0001, W, 1, 0);
    chk(capMiso == 16'h8001, "R9", "miso after error", capMiso, 16'h8001);

    // R11 unsupported delay
    delaySel = 2'b01;
    waitClk(2);
    chk(cfgReject == 1, "R11", "cfgReject", cfgReject, 1);
    v0 = nValid;
    oeSeen = 0;
    xfer(16'h4444, W, 0, 0);
    chk(oeSeen == 0, "R11", "misoOe while rejected", oeSeen, 0);
    chk(nValid == v0 && nUnder == 1, "R11", "no transfer while rejected", nValid, v0);
    delaySel = 2'b00;
    waitClk(2);
    chk(cfgReject == 0, "R11", "cfgReject cleared", cfgReject, 0);

    waitClk(4 * H);
    chk(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);
    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule